// File: doc/BRIEF.md
# Pixel Overlay Selector with Eight-Colour Palette

This block sits in a video encoder datapath between the pixel input latch and the colour-space converter. On each pixel strobe it takes one 24-bit RGB pixel from the main stream, three one-bit overlay colour inputs and an overlay enable. It then produces one 24-bit RGB pixel for the next stage. The overlay inputs form a 3-bit index into a fixed eight-colour palette. While the enable is high, that palette colour replaces the main pixel outright. There is no blending. While the enable is low, the main pixel is passed on unchanged.

A window flag from the video timing block marks active video. Pixels outside that window leave the block as black, whatever the data and overlay inputs carry. Main data and overlay inputs share one capture register stage and one output register stage, so an overlay bit always acts on the pixel it was presented with. The clock runs faster than the pixel rate, and a one-cycle pixel strobe marks each pixel.

Top module: `osd_overlay_mux`

## Requirements
- R1: While reset is asserted, and after it is released until the first output update, `pix_out` is 24'h000000 and `pix_vld` is 0.
- R2: A pixel presented with `pix_ce` high at edge k shows at `pix_out` after the next edge at which `pix_ce` is high. `pix_vld` is high for exactly one cycle after each strobed edge at which the capture stage already held a pixel.
- R3: For an active pixel with `osd_en` low, `pix_out` equals the main pixel `pix_in` bit for bit.
- R4: For an active pixel with `osd_en` high, `pix_out` is the palette colour and the main pixel has no effect on it.
- R5: The palette index is {`osd_r`,`osd_g`,`osd_b`}. Each index bit sets its own component to 8'hFF when 1 and to 8'h00 when 0. The components are red in `pix_out`[23:16], green in [15:8] and blue in [7:0]. So index 3'b111 gives white and 3'b000 gives black.
- R6: A pixel presented with `act_win` low leaves as 24'h000000, whether `osd_en` is high or low.
- R7: While `pix_ce` is low, input changes have no effect. `pix_out` holds its value and `pix_vld` is 0 from the second cycle without a strobe onward.
- R8: The overlay enable and index stay aligned with the main pixel. In a continuous pixel stream, switching the overlay on for a single pixel changes only that pixel's output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Datapath clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| pix_ce | input | 1 | Pixel strobe; one pixel is taken on each edge where it is high |
| pix_in | input | 24 | Main RGB pixel, red [23:16], green [15:8], blue [7:0] |
| osd_r | input | 1 | Overlay red index bit |
| osd_g | input | 1 | Overlay green index bit |
| osd_b | input | 1 | Overlay blue index bit |
| osd_en | input | 1 | Overlay enable; high selects the palette colour for this pixel |
| act_win | input | 1 | High inside the active-video window |
| pix_out | output | 24 | Registered RGB pixel to the colour-space stage |
| pix_vld | output | 1 | One-cycle flag marking a newly updated `pix_out` |

## Verification
Properties are checked on every cycle. The capture registers must hold while no strobe arrives. The valid flag may only follow a strobe. A blanked pixel must come out black. An overlaid pixel must have every component either all ones or all zeros, and a pass-through pixel must equal the main input of the previous strobe. Other behaviour is only shown by the bench's scenarios: the exact index-to-colour mapping for all eight entries, the two-strobe latency, and per-pixel alignment when the overlay toggles inside a continuous stream. The reset values are also checked there.

// File: rtl/osd_pkg.sv
package osd_pkg;
  localparam int unsigned COMP_W_DEF = 8;
  localparam int unsigned NCOMP_DEF  = 3;

  typedef enum logic [1:0] {
    SRC_MAIN  = 2'd0,
    SRC_OSD   = 2'd1,
    SRC_BLANK = 2'd2
  } src_sel_e;
endpackage

// File: rtl/osd_capture.sv
module osd_capture #(
  parameter int unsigned PIX_W = 24,
  parameter int unsigned IDX_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ce_i,
  input  logic [PIX_W-1:0] pix_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic             ovl_i,
  input  logic             act_i,
  output logic [PIX_W-1:0] pix_q,
  output logic [IDX_W-1:0] idx_q,
  output logic             ovl_q,
  output logic             act_q,
  output logic             full_q
);
  logic [PIX_W-1:0] pix_d;
  logic [IDX_W-1:0] idx_d;
  logic             ovl_d, act_d, full_d;

  always_comb begin
    pix_d  = pix_q;
    idx_d  = idx_q;
    ovl_d  = ovl_q;
    act_d  = act_q;
    full_d = full_q;
    if (ce_i) begin
      pix_d  = pix_i;
      idx_d  = idx_i;
      ovl_d  = ovl_i;
      act_d  = act_i;
      full_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pix_q  <= '0;
      idx_q  <= '0;
      ovl_q  <= 1'b0;
      act_q  <= 1'b0;
      full_q <= 1'b0;
    end else begin
      pix_q  <= pix_d;
      idx_q  <= idx_d;
      ovl_q  <= ovl_d;
      act_q  <= act_d;
      full_q <= full_d;
    end
  end

  // R7
  cap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ce_i |=> ($stable(pix_q) && $stable(idx_q) && $stable(ovl_q) && $stable(act_q)));
endmodule

// File: rtl/osd_palette.sv
module osd_palette #(
  parameter int unsigned COMP_W = 8,
  parameter int unsigned NCOMP  = 3,
  localparam int unsigned PIX_W = COMP_W * NCOMP
) (
  input  logic [NCOMP-1:0] idx_i,
  output logic [PIX_W-1:0] col_o
);
  for (genvar c = 0; c < NCOMP; c++) begin : g_comp
    assign col_o[c*COMP_W +: COMP_W] = {COMP_W{idx_i[c]}};
  end
endmodule

// File: rtl/osd_select.sv
module osd_select
  import osd_pkg::*;
#(
  parameter int unsigned COMP_W = 8,
  parameter int unsigned NCOMP  = 3,
  localparam int unsigned PIX_W = COMP_W * NCOMP
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ce_i,
  input  logic             full_i,
  input  logic [PIX_W-1:0] main_i,
  input  logic [PIX_W-1:0] pal_i,
  input  logic             ovl_i,
  input  logic             act_i,
  output logic [PIX_W-1:0] pix_q,
  output logic             vld_q
);
  src_sel_e         src;
  logic [PIX_W-1:0] mux_pix;
  logic [PIX_W-1:0] pix_d;
  logic             vld_d;

  always_comb begin
    if (!act_i)     src = SRC_BLANK;
    else if (ovl_i) src = SRC_OSD;
    else            src = SRC_MAIN;
    unique case (src)
      SRC_MAIN: mux_pix = main_i;
      SRC_OSD:  mux_pix = pal_i;
      default:  mux_pix = '0;
    endcase
    pix_d = ce_i ? mux_pix : pix_q;
    vld_d = ce_i & full_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pix_q <= '0;
      vld_q <= 1'b0;
    end else begin
      pix_q <= pix_d;
      vld_q <= vld_d;
    end
  end

  // R6
  blank_black_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ce_i && !act_i) |=> (pix_q == '0));
  // R3
  pass_main_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ce_i && act_i && !ovl_i) |=> (pix_q == $past(main_i)));
  // R2
  vld_after_ce_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vld_q |-> $past(ce_i));
  // R7
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ce_i |=> $stable(pix_q));

  for (genvar c = 0; c < NCOMP; c++) begin : g_full_scale
    // R4
    osd_full_scale_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ce_i && act_i && ovl_i) |=>
        (pix_q[c*COMP_W +: COMP_W] == '0 || pix_q[c*COMP_W +: COMP_W] == '1));
  end
endmodule

// File: rtl/osd_overlay_mux.sv
module osd_overlay_mux
  import osd_pkg::*;
#(
  parameter int unsigned COMP_W = COMP_W_DEF,
  parameter int unsigned NCOMP  = NCOMP_DEF,
  localparam int unsigned PIX_W = COMP_W * NCOMP
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pix_ce,
  input  logic [PIX_W-1:0] pix_in,
  input  logic             osd_r,
  input  logic             osd_g,
  input  logic             osd_b,
  input  logic             osd_en,
  input  logic             act_win,
  output logic [PIX_W-1:0] pix_out,
  output logic             pix_vld
);
  logic [1:0]       rst_sync;
  logic             rst_int_n;
  logic [PIX_W-1:0] cap_pix;
  logic [NCOMP-1:0] cap_idx;
  logic             cap_ovl, cap_act, cap_full;
  logic [PIX_W-1:0] pal_col;
  logic [NCOMP-1:0] osd_idx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_int_n = rst_sync[1];

  assign osd_idx = NCOMP'({osd_r, osd_g, osd_b});

  osd_capture #(.PIX_W(PIX_W), .IDX_W(NCOMP)) u_cap (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .ce_i   (pix_ce),
    .pix_i  (pix_in),
    .idx_i  (osd_idx),
    .ovl_i  (osd_en),
    .act_i  (act_win),
    .pix_q  (cap_pix),
    .idx_q  (cap_idx),
    .ovl_q  (cap_ovl),
    .act_q  (cap_act),
    .full_q (cap_full)
  );

  osd_palette #(.COMP_W(COMP_W), .NCOMP(NCOMP)) u_pal (
    .idx_i (cap_idx),
    .col_o (pal_col)
  );

  osd_select #(.COMP_W(COMP_W), .NCOMP(NCOMP)) u_sel (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .ce_i   (pix_ce),
    .full_i (cap_full),
    .main_i (cap_pix),
    .pal_i  (pal_col),
    .ovl_i  (cap_ovl),
    .act_i  (cap_act),
    .pix_q  (pix_out),
    .vld_q  (pix_vld)
  );

  // R1
  reset_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rst_int_n |=> (pix_out == '0 && !pix_vld));
endmodule

// File: tb/osd_overlay_mux_tb.sv
module osd_overlay_mux_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        pix_ce;
  logic [23:0] pix_in;
  logic        osd_r, osd_g, osd_b, osd_en, act_win;
  logic [23:0] pix_out;
  logic        pix_vld;
  int          n_checks = 0;
  int          n_errors = 0;

  always #5 clk = ~clk;

  osd_overlay_mux dut_i (
    .clk(clk), .rst_n(rst_n), .pix_ce(pix_ce), .pix_in(pix_in),
    .osd_r(osd_r), .osd_g(osd_g), .osd_b(osd_b), .osd_en(osd_en),
    .act_win(act_win), .pix_out(pix_out), .pix_vld(pix_vld)
  );

  task automatic check(input string req, input logic [23:0] act, input logic [23:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [23:0] pal(input logic [2:0] idx);
    return {{8{idx[2]}}, {8{idx[1]}}, {8{idx[0]}}};
  endfunction

  task automatic drive(input logic ce, input logic [23:0] rgb, input logic [2:0] idx,
                       input logic en, input logic act);
    @(negedge clk);
    pix_ce = ce; pix_in = rgb; {osd_r, osd_g, osd_b} = idx; osd_en = en; act_win = act;
  endtask

  // one pixel, one bubble, then check the pixel at the output
  task automatic pixel_check(input string req, input logic [23:0] rgb, input logic [2:0] idx,
                             input logic en, input logic act, input logic [23:0] exp);
    drive(1'b1, rgb, idx, en, act);
    drive(1'b1, 24'h0, 3'b000, 1'b0, 1'b0);
    drive(1'b0, 24'h0, 3'b000, 1'b0, 1'b0);
    check(req, pix_out, exp);
    check({req, " vld"}, {23'h0, pix_vld}, 24'h1);
  endtask

  task automatic t_reset;
    rst_n = 1'b0; pix_ce = 1'b0; pix_in = 24'h0;
    {osd_r, osd_g, osd_b} = 3'b000; osd_en = 1'b0; act_win = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 reset pix_out", pix_out, 24'h0);
    check("R1 reset pix_vld", {23'h0, pix_vld}, 24'h0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 after release", {pix_out[22:0], pix_vld}, 24'h0);
  endtask

  task automatic t_pass;
    pixel_check("R3 pass a", 24'h12_34_56, 3'b111, 1'b0, 1'b1, 24'h12_34_56);
    pixel_check("R3 pass b", 24'hA5_0F_F0, 3'b010, 1'b0, 1'b1, 24'hA5_0F_F0);
  endtask

  task automatic t_palette;
    for (int i = 0; i < 8; i++) begin
      pixel_check($sformatf("R5 R4 idx %0d", i), 24'h5A_C3_3C, 3'(i), 1'b1, 1'b1, pal(3'(i)));
    end
    pixel_check("R5 white", 24'h0, 3'b111, 1'b1, 1'b1, 24'hFF_FF_FF);
    pixel_check("R4 main ignored", 24'hFF_FF_FF, 3'b000, 1'b1, 1'b1, 24'h00_00_00);
  endtask

  task automatic t_blank;
    pixel_check("R6 blank main", 24'h77_88_99, 3'b000, 1'b0, 1'b0, 24'h0);
    pixel_check("R6 blank osd", 24'h77_88_99, 3'b111, 1'b1, 1'b0, 24'h0);
  endtask

  task automatic t_hold;
    pixel_check("R7 setup", 24'hC0_FF_EE, 3'b000, 1'b0, 1'b1, 24'hC0_FF_EE);
    drive(1'b0, 24'h11_22_33, 3'b101, 1'b1, 1'b1);
    drive(1'b0, 24'h44_55_66, 3'b011, 1'b0, 1'b1);
    drive(1'b0, 24'h77_77_77, 3'b111, 1'b1, 1'b0);
    check("R7 hold out", pix_out, 24'hC0_FF_EE);
    check("R7 vld low", {23'h0, pix_vld}, 24'h0);
  endtask

  task automatic t_latency;
    drive(1'b1, 24'hDE_AD_01, 3'b000, 1'b0, 1'b1);
    drive(1'b0, 24'h0, 3'b000, 1'b0, 1'b0);
    // bubble left by previous task comes out first (black, inactive)
    check("R2 first strobe gives older pixel", pix_out, 24'h0);
    check("R2 vld after strobe", {23'h0, pix_vld}, 24'h1);
    drive(1'b0, 24'h0, 3'b000, 1'b0, 1'b0);
    check("R2 vld one cycle", {23'h0, pix_vld}, 24'h0);
    drive(1'b1, 24'h0, 3'b000, 1'b0, 1'b0);
    drive(1'b0, 24'h0, 3'b000, 1'b0, 1'b0);
    check("R2 second strobe gives pixel", pix_out, 24'hDE_AD_01);
  endtask

  task automatic t_align;
    drive(1'b1, 24'h10_20_30, 3'b110, 1'b0, 1'b1);
    drive(1'b1, 24'h40_50_60, 3'b110, 1'b1, 1'b1);
    drive(1'b1, 24'h70_80_90, 3'b110, 1'b0, 1'b1);
    check("R8 pixel 0 main", pix_out, 24'h10_20_30);
    drive(1'b1, 24'h0, 3'b000, 1'b0, 1'b0);
    check("R8 pixel 1 osd", pix_out, 24'hFF_FF_00);
    drive(1'b1, 24'h0, 3'b000, 1'b0, 1'b0);
    check("R8 pixel 2 main", pix_out, 24'h70_80_90);
    drive(1'b0, 24'h0, 3'b000, 1'b0, 1'b0);
  endtask

  initial begin
    t_reset();
    t_pass();
    t_palette();
    t_blank();
    t_hold();
    t_latency();
    t_align();
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++;
    n_errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule